// File: doc/BRIEF.md
# Chroma-Upsampling Colour Converter with Per-Channel Display Curves

This block takes a stream of pixels in which luma arrives for every pixel but the two colour-difference samples are meaningful only on even positions of a line. It fills in the missing colour-difference values by interpolating between neighbouring co-sited samples. It then maps each pixel to monitor red, green and blue through a programmable three-by-three matrix with a per-channel offset. As a last step it applies the display non-linearity separately to each channel through a writable 256-entry table.

The non-linearity is applied only after the conversion to monitor primaries, and each channel's table sees only that channel's matrix result. Pixels enter and leave through valid/ready handshakes. When the output is not ready, every stage of the pipeline holds. A simple write port loads the matrix, the offsets and the table contents.

Top module: `yuv_gamma_pipe`

## Requirements
- R1: While reset is held and immediately after it, out_valid is 0 and in_ready is 1.
- R2: Pixel positions in a line count from 0 and restart after a beat with in_last=1. An even-position pixel uses its own in_cb/in_cr. An odd-position pixel uses (a+b+1)>>1 of the chroma of the even pixels just before and just after it in the same line. An odd pixel that ends the line repeats the chroma of the even pixel before it. An even pixel that ends the line keeps its own chroma.
- R3: in_cb and in_cr presented with odd-position pixels have no effect on any output.
- R4: Each channel computes s = KY*Y + KU*(U-128) + KV*(V-128). The coefficients are signed 12-bit values with 8 fractional bits. The result is floor((s+128)/256) plus the channel's signed 16-bit integer offset.
- R5: The matrix result is clamped to 0 when negative and to 255 when above 255 before it indexes the table.
- R6: The output of each channel is the entry of that channel's own table at the clamped index. Writing one channel's table leaves the other two channels unchanged.
- R7: After reset, entry i of every table is floor(255*(i/255)^2.2 + 0.5).
- R8: After reset, the coefficients (KY,KU,KV) are (256,0,359) for red, (256,-88,-183) for green and (256,454,0) for blue, and all offsets are 0.
- R9: A write with cfg_we=1 and cfg_addr[9:8]=0, 1 or 2 loads table red, green or blue at entry cfg_addr[7:0] from cfg_wdata[7:0]. When cfg_addr[9:8]=3, cfg_addr[3:2] picks the channel (0 red, 1 green, 2 blue) and cfg_addr[1:0] picks the slot: 0 KY, 1 KU, 2 KV (each from cfg_wdata[11:0]), or 3 offset (from cfg_wdata[15:0]). A write made while no pixel is in flight applies to every pixel accepted after it.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and the output pixel holds its values into the next cycle. With any pattern of input gaps and output stalls, the pixels leave in order and none is lost.
- R11: The pipeline has four register stages. With out_ready held at 1, the even pixel of a pair is valid at the output from the third rising edge after the edge that accepts its odd partner.
- R12: In the cycle after a beat with in_last=1 is accepted, in_ready is 0 while the final pixel of the line is pushed into the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel accepted at this edge when in_valid is 1 |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference sample, offset binary; used on even positions only |
| in_cr | input | 8 | Red-difference sample, offset binary; used on even positions only |
| in_last | input | 1 | Marks the final pixel of a line |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |

## Verification
The assertions assume that the downstream side is allowed to hold out_ready low for any number of cycles and that in_last may fall on either parity. They do not assume any particular spacing of input beats. The latency property only counts cases where out_ready stayed high for the whole transit, because a stall anywhere in those cycles legitimately stretches it. The stimulus keeps every configuration write to moments when the pipeline has drained, so that the rule about when a write takes effect stays unambiguous. In the stall phase, both the gaps between input beats and the output stalls are irregular.

// File: rtl/yuv_gamma_pipe.sv
`timescale 1ns/1ps
module yuv_gamma_pipe #(
  parameter int DW        = 8,
  parameter int CW        = 12,
  parameter int FRAC      = 8,
  parameter int OW        = 16,
  parameter int GAMMA_X10 = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_y,
  input  logic [DW-1:0]   in_cb,
  input  logic [DW-1:0]   in_cr,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_r,
  output logic [DW-1:0]   out_g,
  output logic [DW-1:0]   out_b,
  input  logic            cfg_we,
  input  logic [DW+1:0]   cfg_addr,
  input  logic [OW-1:0]   cfg_wdata
);

  localparam int TD   = 1 << DW;
  localparam int MAXV = TD - 1;
  localparam int AW   = DW + 2;
  localparam int SW   = CW + DW + 3;
  localparam int HALF = 1 << (DW - 1);
  localparam int RND  = 1 << (FRAC - 1);
  localparam int ONE  = 1 << FRAC;

  typedef logic [DW-1:0] tab_t [TD];

  function automatic tab_t gamma_tab();
    tab_t t;
    for (int i = 0; i < TD; i++)
      t[i] = DW'($rtoi(real'(MAXV) * ((real'(i) / real'(MAXV)) ** (real'(GAMMA_X10) / 10.0)) + 0.5));
    return t;
  endfunction

  function automatic logic signed [CW-1:0] kdef(int c, int k);
    real w;
    w = 0.0;
    if (k == 0)                w = 1.0;
    else if (c == 0 && k == 2) w = 1.402;
    else if (c == 1 && k == 1) w = -0.344;
    else if (c == 1 && k == 2) w = -0.714;
    else if (c == 2 && k == 1) w = 1.772;
    return CW'($rtoi(w * real'(ONE) + ((w < 0.0) ? -0.5 : 0.5)));
  endfunction

  localparam tab_t GTAB = gamma_tab();

  logic          ph, pend_v, flush;
  logic [DW-1:0] pend_y, prev_cb, prev_cr;
  logic          en, acc, take_even, take_odd;
  logic [DW:0]   sum_cb, sum_cr;
  logic          s1_v, s2_v, s3_v, s4_v;
  logic [DW-1:0] s1_y, s1_cb, s1_cr;
  logic signed [DW+1:0] ys, us, vs;
  logic [DW-1:0] res [3];

  assign en        = ~s4_v | out_ready;
  assign in_ready  = en & ~flush;
  assign acc       = in_valid & in_ready;
  assign take_even = acc & ~ph;
  assign take_odd  = acc & ph;
  assign sum_cb    = {1'b0, prev_cb} + {1'b0, in_cb} + (DW+1)'(1);
  assign sum_cr    = {1'b0, prev_cr} + {1'b0, in_cr} + (DW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0; pend_v <= 1'b0; flush <= 1'b0;
      pend_y <= '0; prev_cb <= '0; prev_cr <= '0;
      s1_v <= 1'b0; s1_y <= '0; s1_cb <= '0; s1_cr <= '0;
    end else if (en) begin
      s1_v  <= flush | take_odd | (take_even & pend_v);
      s1_y  <= pend_y;
      s1_cb <= take_even ? sum_cb[DW:1] : prev_cb;
      s1_cr <= take_even ? sum_cr[DW:1] : prev_cr;
      if (flush) begin
        flush  <= 1'b0;
        pend_v <= 1'b0;
        ph     <= 1'b0;
      end else if (acc) begin
        pend_y <= in_y;
        pend_v <= 1'b1;
        ph     <= in_last ? 1'b0 : ~ph;
        flush  <= in_last;
        if (take_even) begin
          prev_cb <= in_cb;
          prev_cr <= in_cr;
        end
      end
    end
  end

  assign ys = {2'b00, s1_y};
  assign us = $signed({2'b00, s1_cb}) - (DW+2)'(HALF);
  assign vs = $signed({2'b00, s1_cr}) - (DW+2)'(HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s3_v <= 1'b0; s4_v <= 1'b0;
    end else if (en) begin
      s2_v <= s1_v; s3_v <= s2_v; s4_v <= s3_v;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    localparam logic signed [CW-1:0] KY0 = kdef(c, 0);
    localparam logic signed [CW-1:0] KU0 = kdef(c, 1);
    localparam logic signed [CW-1:0] KV0 = kdef(c, 2);

    logic signed [CW-1:0] ky, ku, kv;
    logic signed [OW-1:0] ko;
    logic signed [SW-1:0] s2_sum;
    logic signed [SW:0]   tot;
    logic [DW-1:0]        idx, s3_idx, q;
    logic [DW-1:0]        lut [TD];
    logic                 kwr;

    assign kwr = cfg_we && cfg_addr[AW-1:DW] == 2'b11 && cfg_addr[3:2] == 2'(c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ky <= KY0; ku <= KU0; kv <= KV0; ko <= '0;
      end else if (kwr) begin
        case (cfg_addr[1:0])
          2'd0:    ky <= cfg_wdata[CW-1:0];
          2'd1:    ku <= cfg_wdata[CW-1:0];
          2'd2:    kv <= cfg_wdata[CW-1:0];
          default: ko <= cfg_wdata;
        endcase
      end
    end

    always_comb begin
      tot = (SW+1)'((s2_sum + RND) >>> FRAC) + (SW+1)'(ko);
      if (tot < 0)         idx = '0;
      else if (tot > MAXV) idx = DW'(MAXV);
      else                 idx = tot[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s2_sum <= '0; s3_idx <= '0; q <= '0;
      end else if (en) begin
        s2_sum <= SW'(ky * ys) + SW'(ku * us) + SW'(kv * vs);
        s3_idx <= idx;
        q      <= lut[s3_idx];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < TD; i++) lut[i] <= GTAB[i];
      end else if (cfg_we && cfg_addr[AW-1:DW] == 2'(c)) begin
        lut[cfg_addr[DW-1:0]] <= cfg_wdata[DW-1:0];
      end
    end

    assign res[c] = q;
  end

  assign out_valid = s4_v;
  assign out_r = res[0];
  assign out_g = res[1];
  assign out_b = res[2];

endmodule

// File: rtl/yuv_gamma_pipe_chk.sv
`timescale 1ns/1ps
module yuv_gamma_pipe_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_r,
  input logic [DW-1:0] out_g,
  input logic [DW-1:0] out_b,
  input logic          take_odd
);

  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b));

  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5) && $past(take_odd, 4) && $past(out_ready, 3) && $past(out_ready, 2)
      && $past(out_ready, 1) |-> out_valid);

endmodule

bind yuv_gamma_pipe yuv_gamma_pipe_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_yuv_gamma_pipe.sv
`timescale 1ns/1ps
module test_yuv_gamma_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_r, out_g, out_b;
  logic cfg_we = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;

  yuv_gamma_pipe i_yuv_gamma_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  string cur_req = "R1";
  int cm [3][3];
  int co [3];
  int tl [3][256];
  int ly [64], lcb [64], lcr [64];
  logic [23:0] exp_q [$];
  int last_acc = 0;
  bit stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic void check(string req, bit ok, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  logic [23:0] held;
  bit held_f = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_f) begin
        check("R10", out_valid && {out_r, out_g, out_b} == held, int'({out_r, out_g, out_b}), int'(held));
        held_f = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(cur_req, 1'b0, int'({out_r, out_g, out_b}), -1);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check(cur_req, {out_r, out_g, out_b} == e, int'({out_r, out_g, out_b}), int'(e));
        end
      end else if (out_valid) begin
        held = {out_r, out_g, out_b};
        held_f = 1'b1;
        check("R10", in_ready == 1'b0, int'(in_ready), 0);
      end
    end
  end

  function automatic int sgn(int d, int w);
    int m;
    m = d & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  function automatic int pix(int c, int y, int u, int v);
    int s, r;
    s = cm[c][0] * y + cm[c][1] * (u - 128) + cm[c][2] * (v - 128);
    r = ((s + 128) >>> 8) + co[c];
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return tl[c][r];
  endfunction

  task automatic cfg_write(int a, int d);
    cfg_we = 1'b1; cfg_addr = 10'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if ((a >> 8) < 3) tl[a >> 8][a & 255] = d & 255;
    else if (((a >> 2) & 3) < 3) begin
      if ((a & 3) == 3) co[(a >> 2) & 3] = sgn(d, 16);
      else cm[(a >> 2) & 3][a & 3] = sgn(d, 12);
    end
  endtask

  task automatic send_line(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      int u, v;
      if (i % 2 == 0) begin u = lcb[i]; v = lcr[i]; end
      else if (i + 1 < n) begin
        u = (lcb[i-1] + lcb[i+1] + 1) / 2;
        v = (lcr[i-1] + lcr[i+1] + 1) / 2;
      end else begin u = lcb[i-1]; v = lcr[i-1]; end
      exp_q.push_back({8'(pix(0, ly[i], u, v)), 8'(pix(1, ly[i], u, v)), 8'(pix(2, ly[i], u, v))});
    end
    for (int i = 0; i < n; i++) begin
      bit ok;
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      in_valid = 1'b1; in_y = 8'(ly[i]); in_cb = 8'(lcb[i]); in_cr = 8'(lcr[i]);
      in_last = (i == n - 1);
      do begin
        #1; ok = in_ready;
        @(negedge clk);
      end while (!ok);
      last_acc = cyc;
      in_valid = 1'b0; in_last = 1'b0;
      if (i == n - 1) begin
        #1;
        check("R12", in_ready == 1'b0, int'(in_ready), 0);
      end
    end
  endtask

  task automatic rand_line(int n);
    for (int i = 0; i < n; i++) begin
      ly[i] = $urandom_range(0, 255); lcb[i] = $urandom_range(0, 255); lcr[i] = $urandom_range(0, 255);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all();
    cur_req = "R7";
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 64; i++) begin ly[i] = l * 64 + i; lcb[i] = 128; lcr[i] = 128; end
      send_line(64, 1'b0);
    end
    drain();

    cur_req = "R8";
    for (int l = 0; l < 8; l++) begin rand_line(16); send_line(16, 1'b0); end
    drain();

    cur_req = "R11";
    rand_line(2);
    send_line(2, 1'b0);
    while (!out_valid) @(negedge clk);
    check("R11", cyc - last_acc == 3, cyc - last_acc, 3);
    drain();

    cur_req = "R9";
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 256; i++) cfg_write(c * 256 + i, i);
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 3; k++) cfg_write(768 + c * 4 + k, (k == c) ? 256 : 0);
    cfg_write(768 + 4 + 3, 128);
    cfg_write(768 + 8 + 3, 128);
    cfg_write(768 + 0, 256);
    cfg_write(768 + 4 + 0, 0); cfg_write(768 + 4 + 1, 256);
    cfg_write(768 + 8 + 0, 0); cfg_write(768 + 8 + 2, 256);
    for (int i = 0; i < 8; i++) begin ly[i] = i * 30; lcb[i] = 255 - i * 20; lcr[i] = i * 20; end
    send_line(8, 1'b0);
    drain();

    cur_req = "R2";
    for (int n = 2; n <= 20; n++) begin rand_line(n); send_line(n, 1'b0); end
    drain();

    cur_req = "R3";
    for (int l = 0; l < 6; l++) begin
      rand_line(12);
      send_line(12, 1'b0);
      for (int i = 1; i < 12; i += 2) begin lcb[i] = 255 - lcb[i]; lcr[i] = $urandom_range(0, 255); end
      send_line(12, 1'b0);
    end
    drain();

    cur_req = "R4";
    cfg_write(768 + 8 + 0, 100); cfg_write(768 + 8 + 1, 12'hFDB);
    cfg_write(768 + 8 + 2, 77);  cfg_write(768 + 8 + 3, 5);
    for (int l = 0; l < 6; l++) begin rand_line(16); send_line(16, 1'b0); end
    drain();

    cur_req = "R5";
    cfg_write(768 + 3, 200);
    cfg_write(768 + 4 + 3, 16'hFF9C);
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 64; i++) begin
        ly[i] = l * 64 + i; lcb[i] = $urandom_range(0, 255); lcr[i] = $urandom_range(0, 255);
      end
      send_line(64, 1'b0);
    end
    drain();

    cur_req = "R6";
    for (int i = 0; i < 256; i++) cfg_write(i, 255 - i);
    for (int l = 0; l < 6; l++) begin rand_line(16); send_line(16, 1'b0); end
    drain();

    cur_req = "R10";
    stall_mode = 1'b1;
    for (int l = 0; l < 30; l++) begin
      int n;
      n = $urandom_range(1, 24);
      rand_line(n);
      send_line(n, 1'b1);
    end
    drain();
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      co[c] = 0;
      for (int i = 0; i < 256; i++)
        tl[c][i] = $rtoi(255.0 * ((real'(i) / 255.0) ** 2.2) + 0.5);
    end
    cm[0][0] = 256; cm[0][1] = 0;   cm[0][2] = 359;
    cm[1][0] = 256; cm[1][1] = -88; cm[1][2] = -183;
    cm[2][0] = 256; cm[2][1] = 454; cm[2][2] = 0;

    repeat (3) @(negedge clk);
    check("R1", out_valid == 1'b0, int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1", out_valid == 1'b0 && in_ready == 1'b1, int'({out_valid, in_ready}), 1);
    @(negedge clk);

    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL %s watchdog expired actual=%0d expected=%0d", cur_req, exp_q.size(), 0);
      end
    join_any
    disable fork;

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule